// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous static memory with its own cycle decoder. On every rising clock edge it looks at two address strobes, three chip enables and a set of write controls, and decides whether the edge deselects the memory, begins a new access, or continues the access already open. The access address comes from an external burst sequencer on every edge, so the block itself never counts addresses. Writes land in the array on the edge that samples them, byte by byte or as a whole word.

Reads leave through one of two paths. In pipelined mode the word read at one edge goes into an output register and appears after the next edge. In flow-through mode that register is bypassed and the word appears right after the edge that took the address. A drive-enable output stands in for tri-state pins: it is high only while valid read data is on the data output. A sleep input freezes all accesses and keeps the stored words.

Top module: `sram_burst_core`

## Requirements
- R1: Byte lane b (bits [b*BYTE_W +: BYTE_W], gated by `byte_sel_n[b]`) is written on an access edge when `wr_all_n` is low, or when `wr_bytes_n` is low together with `byte_sel_n[b]` low; `wr_all_n` low writes every lane whatever `byte_sel_n` holds.
- R2: With `wr_all_n` high, an access edge is a read when `wr_bytes_n` is high or when every `byte_sel_n` bit is high.
- R3: An edge with `strobe_cpu_n` low and `cs_main_n` low begins a read whatever the write controls hold; the array is left unchanged.
- R4: An edge with `strobe_ctl_n` low and `strobe_cpu_n` high begins an access whose write controls are sampled on that same edge, so it may begin a write.
- R5: While the memory is deselected, `strobe_cpu_n` low with `cs_main_n` high (and `strobe_ctl_n` high) begins nothing and the memory stays deselected.
- R6: A strobe edge (`strobe_ctl_n` low, or `strobe_cpu_n` low with `cs_main_n` low) while any enable is inactive (`cs_main_n` high, `cs_hi` low or `cs_lo_n` high) deselects; `drive_en` is low in the following cycle in both read modes, and later edges without a strobe perform no access.
- R7: Once an access has begun, each edge without a strobe continues it at the address then present, sampling the write controls on that edge.
- R8: With `flow_n` high (pipelined), a read taken at edge E drives its word with `drive_en` high after edge E+1, and `drive_en` is low after edge E when the edge before E was not a read.
- R9: With `flow_n` low (flow-through), a read taken at edge E drives its word with `drive_en` high right after edge E.
- R10: After an edge that performs a write, `drive_en` is low for the following cycle, even with `oe_n` low and a read still in the output register.
- R11: `oe_n` high forces `drive_en` low without waiting for a clock edge.
- R12: While `sleep` is high no access takes place (writes are dropped) and `drive_en` is low; stored words are kept and readable after `sleep` falls.
- R13: After synchronous reset the memory is deselected and `drive_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all edges are rising edges |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Access address from the burst sequencer |
| wdata | input | BYTES*BYTE_W | Write data, taken on the write edge |
| cs_main_n | input | 1 | Main chip enable, active low; blocks the processor strobe |
| cs_hi | input | 1 | Chip enable, active high |
| cs_lo_n | input | 1 | Chip enable, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| wr_all_n | input | 1 | Whole-word write enable, active low |
| wr_bytes_n | input | 1 | Byte write qualifier, active low |
| byte_sel_n | input | BYTES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | Low selects flow-through reads, high pipelined |
| sleep | input | 1 | Low-power hold; no access while high |
| rdata | output | BYTES*BYTE_W | Read data |
| drive_en | output | 1 | High while rdata should drive the pins |

## Verification
The bench builds the block with two 9-bit lanes (an 18-bit word) and a 16-word array, so a byte write that stops at the lane boundary between bits 8 and 9 is visible in a single read-back. The small array keeps every address the sequence touches known, and both read modes and every deselect cause run over the same few words so that a stale pipeline stage or a dropped write shows up as a wrong word or a wrong drive flag.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    // What one clock edge does to the memory.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_DESEL = 2'd1,
        CYC_BEGIN = 2'd2,
        CYC_CONT  = 2'd3
    } cyc_e;

    // Decoded access for one edge.
    typedef struct packed {
        cyc_e kind;
        logic rd;
        logic wr;
    } acc_t;

    // All three enables in their active state.
    function automatic logic chips_on(input logic main_n, input logic hi, input logic lo_n);
        return (!main_n) && hi && (!lo_n);
    endfunction

    // Processor strobe is honoured only with the main enable active.
    function automatic logic cpu_start(input logic cpu_n, input logic main_n);
        return (!cpu_n) && (!main_n);
    endfunction

    function automatic logic is_access(input cyc_e k);
        return (k == CYC_BEGIN) || (k == CYC_CONT);
    endfunction

endpackage

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
    import sram_cyc_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep,
    input  logic             cs_main_n,
    input  logic             cs_hi,
    input  logic             cs_lo_n,
    input  logic             strobe_cpu_n,
    input  logic             strobe_ctl_n,
    input  logic             wr_all_n,
    input  logic             wr_bytes_n,
    input  logic [BYTES-1:0] byte_sel_n,
    output acc_t             acc,
    output logic [BYTES-1:0] wen
);

    logic             sel_q;
    logic             cpu_go;
    logic             strobe_seen;
    logic             take_we;
    logic [BYTES-1:0] wen_raw;

    always_comb begin
        wen_raw     = {BYTES{~wr_all_n}} | ({BYTES{~wr_bytes_n}} & ~byte_sel_n);
        cpu_go      = cpu_start(strobe_cpu_n, cs_main_n);
        strobe_seen = cpu_go | ~strobe_ctl_n;
        acc         = '0;
        take_we     = 1'b0;
        if (!sleep) begin
            if (strobe_seen) begin
                if (chips_on(cs_main_n, cs_hi, cs_lo_n)) begin
                    acc.kind = CYC_BEGIN;
                    take_we  = ~cpu_go;
                end else begin
                    acc.kind = CYC_DESEL;
                end
            end else if (sel_q) begin
                acc.kind = CYC_CONT;
                take_we  = 1'b1;
            end
        end
        wen    = (is_access(acc.kind) && take_we) ? wen_raw : '0;
        acc.wr = |wen;
        acc.rd = is_access(acc.kind) && !(|wen);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (acc.kind == CYC_BEGIN) begin
            sel_q <= 1'b1;
        end else if (acc.kind == CYC_DESEL) begin
            sel_q <= 1'b0;
        end
    end

    // R3: a processor-strobe edge never writes
    a_r3_cpu_start_reads: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strobe_cpu_n && !cs_main_n) |-> (wen == '0));

    // R6: a deselect edge leaves the memory deselected
    a_r6_desel_drops_sel: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strobe_ctl_n && !cs_hi) |=> !sel_q);

    // R5: blocked processor strobe does not select
    a_r5_cpu_blocked: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && !sleep && cs_main_n && strobe_ctl_n) |=> !sel_q);

    // R12: no access while asleep
    a_r12_sleep_no_access: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (!acc.rd && !acc.wr && (wen == '0)));

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    parameter int AW     = 6
) (
    input  logic                    clk,
    input  logic [AW-1:0]           waddr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [BYTES-1:0]        wen,
    input  logic [AW-1:0]           raddr,
    output logic [BYTES*BYTE_W-1:0] rword
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wen[b]) begin
                lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rword[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/sram_read_stage.sv
module sram_read_stage
    import sram_cyc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flow_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  acc_t              acc,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] rword,
    output logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata,
    output logic              drive_en
);

    logic              rd_q;
    logic              wr_q;
    logic              pipe_q;
    logic [AW-1:0]     addr_q;
    logic [WORD_W-1:0] dout_q;
    logic              word_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            pipe_q <= 1'b0;
            addr_q <= '0;
            dout_q <= '0;
        end else begin
            rd_q   <= acc.rd;
            wr_q   <= acc.wr;
            pipe_q <= rd_q && (acc.kind != CYC_DESEL);
            if (acc.rd) begin
                addr_q <= addr;
            end
            if (rd_q) begin
                dout_q <= rword;
            end
        end
    end

    always_comb begin
        raddr      = addr_q;
        word_ready = flow_n ? pipe_q : rd_q;
        rdata      = flow_n ? dout_q : rword;
        drive_en   = word_ready && !wr_q && !oe_n && !sleep;
    end

    // R10: a write edge blanks the output for the next cycle
    a_r10_write_blanks: assert property (@(posedge clk) disable iff (rst)
        acc.wr |=> !drive_en);

    // R6: a deselect edge blanks the output in both read modes
    a_r6_desel_blanks: assert property (@(posedge clk) disable iff (rst)
        (acc.kind == CYC_DESEL) |=> !drive_en);

endmodule

// File: rtl/sram_burst_core.sv
module sram_burst_core
    import sram_cyc_pkg::*;
#(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    parameter int AW     = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic                    cs_main_n,
    input  logic                    cs_hi,
    input  logic                    cs_lo_n,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    wr_all_n,
    input  logic                    wr_bytes_n,
    input  logic [BYTES-1:0]        byte_sel_n,
    input  logic                    oe_n,
    input  logic                    flow_n,
    input  logic                    sleep,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic                    drive_en
);

    localparam int WORD_W = BYTES * BYTE_W;

    acc_t              acc;
    logic [BYTES-1:0]  wen;
    logic [AW-1:0]     raddr;
    logic [WORD_W-1:0] rword;

    sram_cyc_decode #(.BYTES(BYTES)) u_decode (
        .clk          (clk),
        .rst          (rst),
        .sleep        (sleep),
        .cs_main_n    (cs_main_n),
        .cs_hi        (cs_hi),
        .cs_lo_n      (cs_lo_n),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .wr_all_n     (wr_all_n),
        .wr_bytes_n   (wr_bytes_n),
        .byte_sel_n   (byte_sel_n),
        .acc          (acc),
        .wen          (wen)
    );

    sram_byte_array #(.BYTES(BYTES), .BYTE_W(BYTE_W), .AW(AW)) u_array (
        .clk   (clk),
        .waddr (addr),
        .wdata (wdata),
        .wen   (wen),
        .raddr (raddr),
        .rword (rword)
    );

    sram_read_stage #(.WORD_W(WORD_W), .AW(AW)) u_read (
        .clk      (clk),
        .rst      (rst),
        .flow_n   (flow_n),
        .oe_n     (oe_n),
        .sleep    (sleep),
        .acc      (acc),
        .addr     (addr),
        .rword    (rword),
        .raddr    (raddr),
        .rdata    (rdata),
        .drive_en (drive_en)
    );

    // R11: output enable high keeps the pins quiet
    a_r11_oe_quiet: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drive_en);

    // R13: nothing drives in the cycle after reset
    a_r13_reset_quiet: assert property (@(posedge clk)
        rst |=> !drive_en);

endmodule

// File: tb/sram_burst_core_bench.sv
module sram_burst_core_bench;

    localparam int NB = 2;
    localparam int BW = 9;
    localparam int AW = 4;
    localparam int W  = NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic          cs_main_n = 1'b0, cs_hi = 1'b1, cs_lo_n = 1'b0;
    logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1;
    logic          wr_all_n = 1'b1, wr_bytes_n = 1'b1;
    logic [NB-1:0] byte_sel_n = '1;
    logic          oe_n = 1'b0, flow_n = 1'b1, sleep = 1'b0;
    logic [W-1:0]  rdata;
    logic          drive_en;

    int n_checks = 0;
    int n_errors = 0;
    int cyc_n = 0;
    bit done = 0;

    typedef struct {
        int          due;
        bit          drv;
        logic [W-1:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    sram_burst_core #(.BYTES(NB), .BYTE_W(BW), .AW(AW)) u_sram_burst_core (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .byte_sel_n(byte_sel_n),
        .oe_n(oe_n), .flow_n(flow_n), .sleep(sleep),
        .rdata(rdata), .drive_en(drive_en)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc_n <= cyc_n + 1;

    // Monitor: pop every expectation due after the latest edge and compare.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc_n) begin
                n_checks++;
                if (q[i].drv) begin
                    if (drive_en !== 1'b1 || rdata !== q[i].data) begin
                        n_errors++;
                        $display("FAIL %s: drive_en=%0b rdata=%h expected drive_en=1 rdata=%h",
                                 q[i].tag, drive_en, rdata, q[i].data);
                    end
                end else if (drive_en !== 1'b0) begin
                    n_errors++;
                    $display("FAIL %s: drive_en=%0b expected drive_en=0", q[i].tag, drive_en);
                end
                q.delete(i);
            end
        end
    end

    // Driver helpers: expectation offset counts edges from now.
    task automatic expect_at(int off, bit drv, logic [W-1:0] data, string tag);
        exp_t e;
        e.due  = cyc_n + off;
        e.drv  = drv;
        e.data = data;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #2;
    endtask

    task automatic quiet_ctl();
        strobe_cpu_n = 1'b1;
        strobe_ctl_n = 1'b1;
        wr_all_n     = 1'b1;
        wr_bytes_n   = 1'b1;
        byte_sel_n   = '1;
        cs_main_n    = 1'b0;
        cs_hi        = 1'b1;
        cs_lo_n      = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        n_checks++;
        if (drive_en !== 1'b0) begin
            n_errors++;
            $display("FAIL R13: drive_en=%0b expected 0 after reset", drive_en);
        end
        expect_at(1, 0, '0, "R13 idle after reset");
        step();

        // R4 + R1: controller strobe begins a whole-word write
        strobe_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 4'd3; wdata = 18'h2A5A5;
        expect_at(1, 0, '0, "R10 write edge quiet");
        step();
        // R7: continue with another whole-word write
        quiet_ctl(); wr_all_n = 1'b0; addr = 4'd5; wdata = 18'h13C3C;
        expect_at(1, 0, '0, "R7 continued write quiet");
        step();
        // R1: lane 0 only
        quiet_ctl(); wr_bytes_n = 1'b0; byte_sel_n = 2'b10; addr = 4'd5; wdata = 18'h3FFFF;
        expect_at(1, 0, '0, "R1 byte write quiet");
        step();
        // R2: byte qualifier high means read
        quiet_ctl(); byte_sel_n = 2'b00; addr = 4'd5; wdata = '0;
        expect_at(1, 0, '0, "R8 first pipelined edge quiet");
        expect_at(2, 1, 18'h13DFF, "R1 lane merge / R8 pipelined read");
        step();
        // R2: all lane strobes high means read
        quiet_ctl(); wr_bytes_n = 1'b0; byte_sel_n = 2'b11; addr = 4'd3;
        expect_at(2, 1, 18'h2A5A5, "R2 all strobes high reads / R4 write landed");
        step();
        quiet_ctl(); addr = 4'd3;
        step();
        // R6: high-true enable inactive deselects
        quiet_ctl(); strobe_ctl_n = 1'b0; cs_hi = 1'b0;
        expect_at(1, 0, '0, "R6 deselect by cs_hi");
        step();
        quiet_ctl(); addr = 4'd3;
        expect_at(1, 0, '0, "R6 no access after deselect");
        step();
        // R5: processor strobe blocked by main enable
        quiet_ctl(); cs_main_n = 1'b1; strobe_cpu_n = 1'b0; addr = 4'd3;
        expect_at(1, 0, '0, "R5 blocked strobe");
        expect_at(2, 0, '0, "R5 blocked strobe began nothing");
        step();
        quiet_ctl();
        step();
        // R3: processor strobe with write controls active still reads
        quiet_ctl(); strobe_cpu_n = 1'b0; wr_all_n = 1'b0; addr = 4'd3; wdata = '0;
        expect_at(1, 0, '0, "R3 first pipelined edge quiet");
        expect_at(2, 1, 18'h2A5A5, "R3 begin is a read");
        step();
        quiet_ctl(); addr = 4'd3;
        expect_at(2, 1, 18'h2A5A5, "R3 array unchanged");
        step();
        quiet_ctl(); addr = 4'd3;
        step();
        // R6: low-true enable inactive deselects, pipelined word dropped
        quiet_ctl(); strobe_ctl_n = 1'b0; cs_lo_n = 1'b1;
        expect_at(1, 0, '0, "R6 deselect by cs_lo_n clears pipeline");
        step();
        // R9: flow-through begin read
        quiet_ctl(); flow_n = 1'b0; strobe_ctl_n = 1'b0; addr = 4'd5;
        expect_at(1, 1, 18'h13DFF, "R9 flow-through begin");
        step();
        quiet_ctl(); addr = 4'd3;
        expect_at(1, 1, 18'h2A5A5, "R9 flow-through continue");
        step();
        // R11: output enable high
        quiet_ctl(); oe_n = 1'b1; addr = 4'd3;
        expect_at(1, 0, '0, "R11 oe_n high");
        step();
        oe_n = 1'b0;
        // R10: pipelined write after a read, read still in output stage
        quiet_ctl(); flow_n = 1'b1; wr_all_n = 1'b0; addr = 4'd7; wdata = 18'h00F0F;
        expect_at(1, 0, '0, "R10 write blanks pending read");
        step();
        quiet_ctl(); addr = 4'd7;
        expect_at(2, 1, 18'h00F0F, "R7 read after write");
        step();
        quiet_ctl(); addr = 4'd7;
        step();
        // R12: sleep drops the write and quiets the pins
        quiet_ctl(); sleep = 1'b1; wr_all_n = 1'b0; addr = 4'd7; wdata = '0;
        expect_at(1, 0, '0, "R12 sleep quiet");
        step();
        quiet_ctl(); sleep = 1'b0; addr = 4'd7;
        expect_at(1, 0, '0, "R12 no access while asleep");
        expect_at(2, 1, 18'h00F0F, "R12 contents kept");
        step();
        quiet_ctl();
        repeat (3) step();

        if (q.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule